// File: doc/BRIEF.md
# Instant Replay Field Scheduler

This block decides which incoming video fields are written into a circular store of past fields, and when those stored fields are read back for an instant replay. It counts field-start pulses and keeps only a fraction of them while acquisition is running. It does not move any pixels. For every field it keeps, it emits a one-cycle capture strobe with the store slot index. For every field it replays, it emits a one-cycle playback strobe with the slot index to show. An external frame store acts on both strobes.

Acquisition runs while the save/clear control is 1 and every inset window is off. Entering acquisition empties the store. When the control returns to 0, the store is frozen and keeps what it holds. A rising edge on the playback request then replays the stored fields from oldest to newest, at a programmable binary fraction of the acquisition rate, and the block returns to the frozen state. The control state machine has four states: IDLE (empty store), ACQUIRE, FROZEN and REPLAY. Its named transitions are CLEAR (any state other than ACQUIRE to ACQUIRE), HOLD (ACQUIRE to FROZEN, or back to IDLE when nothing was captured), START (FROZEN to REPLAY) and DONE (REPLAY to FROZEN after the newest slot has been shown).

Top module: `replay_field_sched`

## Requirements
- R1: After reset, `status` is 00 (IDLE), and `cap_stb` and `play_stb` are low.
- R2: In ACQUIRE, the first field pulse after entry is captured, and after that one pulse out of every N, with N = 4, 6, 8 or 10 for `acq_rate` = 00, 01, 10, 11. Captured slots count up from 0 and wrap from DEPTH-1 to 0.
- R3: Going from any other state into ACQUIRE clears the store. The next captured slot is 0, the valid count becomes zero, and any replay in progress is aborted, with `status` = 01 one cycle after the request.
- R4: A `save_clear` of 1 has no effect while `inset_on` is not all zeros. The state does not change and no field is captured.
- R5: When `save_clear` falls in ACQUIRE, `status` becomes 10 (FROZEN) if at least one field was captured, or 00 (IDLE) if none was. No capture strobe follows.
- R6: A rising edge of `play_go` in FROZEN starts REPLAY (`status` 11). Holding `play_go` high, lowering it, or raising it in IDLE or ACQUIRE has no effect.
- R7: REPLAY shows the first slot on the first field pulse, then one slot every N·2^S field pulses, with S = `play_rate` (00 gives 1x, 11 gives 1/8x). It starts at the oldest valid slot (slot 0, or the next write slot once the store has wrapped), steps by one with wrap, and after the newest valid slot it returns to FROZEN with no further strobe.
- R8: Each strobe is high for one clock cycle, registered one cycle after the field pulse, and its slot index is valid in that same cycle. A capture strobe and a playback strobe are never high together.
- R9: The `status` encoding is 00 IDLE, 01 ACQUIRE, 10 FROZEN, 11 REPLAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of each incoming field |
| acq_rate | input | 2 | Acquisition decimation select |
| save_clear | input | 1 | 1 = clear the store and acquire, 0 = freeze the store |
| play_rate | input | 2 | Replay slowdown exponent |
| play_go | input | 1 | A rising edge starts a replay |
| inset_on | input | INSET_N | Inset window enables; any 1 blocks clear/acquire |
| cap_stb | output | 1 | Capture the current field |
| cap_slot | output | SLOT_W | Slot to write |
| play_stb | output | 1 | Show a stored field |
| play_slot | output | SLOT_W | Slot to read |
| status | output | 2 | Current state |

## Verification
A wrong write pointer or valid count appears as a wrong `cap_slot` on the next capture strobe. If it does not show there, it appears in the replay: the first `play_slot` is wrong, or the replay ends one strobe early or late. A wrong decimation or replay phase counter moves a strobe by at least one field pulse, so the bench compares every field pulse in the sweep against the arithmetic schedule. A state machine error shows on `status` one clock after the control input changes.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACQ    = 2'b01,
        ST_FROZEN = 2'b10,
        ST_REPLAY = 2'b11
    } rps_state_e;

    // Width of the field phase counters; holds the longest interval (10 << 3 = 80).
    localparam int DIV_W = 7;

    // Fields per capture: 4, 6, 8, 10.
    function automatic logic [DIV_W-1:0] acq_period(input logic [1:0] sel);
        return DIV_W'(4) + DIV_W'({sel, 1'b0});
    endfunction

    // Fields per replayed slot: the capture interval scaled by 2^psel.
    function automatic logic [DIV_W-1:0] play_period(input logic [1:0] asel,
                                                     input logic [1:0] psel);
        return acq_period(asel) << psel;
    endfunction

endpackage

// File: rtl/rps_field_div.sv
// Field-pulse divider: fires on the first pulse after clear, then once per period.
module rps_field_div #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] period,
    output logic         fire
);

    logic [W-1:0] phase;

    assign fire = adv && (phase == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (adv) begin
            // ">=" also recovers when the period shrinks mid-run.
            phase <= (phase >= period - 1'b1) ? '0 : phase + 1'b1;
        end
    end

    // R8: a clear always restarts the schedule on the next pulse
    p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase == '0));

endmodule

// File: rtl/rps_slot_ring.sv
// Write pointer, valid count and replay read cursor of the circular slot store.
module rps_slot_ring #(
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_fire,
    input  logic              play_load,
    input  logic              play_fire,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              empty,
    output logic              last
);

    logic [SLOT_W-1:0] wr_ptr;
    logic [SLOT_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  valid_cnt;
    logic [CNT_W-1:0]  remain;
    logic              full;
    logic [SLOT_W-1:0] oldest;

    function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (valid_cnt == CNT_W'(DEPTH));
    assign oldest  = full ? wr_ptr : '0;
    assign wr_slot = wr_ptr;
    assign rd_slot = rd_ptr;
    assign empty   = (valid_cnt == '0);
    assign last    = (remain == CNT_W'(1));

    // Write side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            valid_cnt <= '0;
        end else if (clear) begin
            wr_ptr    <= '0;
            valid_cnt <= '0;
        end else if (cap_fire) begin
            wr_ptr <= step(wr_ptr);
            if (!full) begin
                valid_cnt <= valid_cnt + 1'b1;
            end
        end
    end

    // Replay side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            remain <= '0;
        end else if (clear) begin
            remain <= '0;
        end else if (play_load) begin
            rd_ptr <= oldest;
            remain <= valid_cnt;
        end else if (play_fire && remain != '0) begin
            rd_ptr <= step(rd_ptr);
            remain <= remain - 1'b1;
        end
    end

    // R2: the valid count never exceeds the store depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_cnt <= CNT_W'(DEPTH));

    // R3: a clear leaves the store empty
    p_clear_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);

    // R7: a replay step is only taken while slots remain
    p_play_has_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (play_fire && !clear && !play_load) |-> (remain != '0));

    // R2: pointers stay inside the store
    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr < SLOT_W'(DEPTH)) || (DEPTH == (1 << SLOT_W)));

endmodule

// File: rtl/rps_ctrl.sv
// Control state machine and registered strobe outputs.
module rps_ctrl
    import rps_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              acq_req,
    input  logic              play_go,
    input  logic              empty,
    input  logic              last,
    input  logic              cap_fire,
    input  logic              play_fire,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              clear,
    output logic              play_load,
    output logic              cap_adv,
    output logic              play_adv,
    output rps_state_e        state,
    output logic              cap_stb,
    output logic [SLOT_W-1:0] cap_slot,
    output logic              play_stb,
    output logic [SLOT_W-1:0] play_slot
);

    rps_state_e state_q;
    rps_state_e state_d;
    logic       go_q;
    logic       go_rise;

    assign go_rise = play_go && !go_q;
    assign state   = state_q;

    // Transition qualifiers
    assign clear     = acq_req && (state_q != ST_ACQ);                       // CLEAR
    assign play_load = (state_q == ST_FROZEN) && !acq_req && go_rise;        // START
    assign cap_adv   = field_start && (state_q == ST_ACQ) && acq_req;
    assign play_adv  = field_start && (state_q == ST_REPLAY) && !acq_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acq_req) state_d = ST_ACQ;
            end
            ST_ACQ: begin
                if (!acq_req) state_d = empty ? ST_IDLE : ST_FROZEN;       // HOLD
            end
            ST_FROZEN: begin
                if (acq_req)      state_d = ST_ACQ;
                else if (go_rise) state_d = ST_REPLAY;
            end
            ST_REPLAY: begin
                if (acq_req)                state_d = ST_ACQ;
                else if (play_fire && last) state_d = ST_FROZEN;           // DONE
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= play_go;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_stb   <= 1'b0;
            cap_slot  <= '0;
            play_stb  <= 1'b0;
            play_slot <= '0;
        end else begin
            cap_stb  <= cap_fire;
            play_stb <= play_fire;
            if (cap_fire)  cap_slot  <= wr_slot;
            if (play_fire) play_slot <= rd_slot;
        end
    end

    // R3: an acquire request outside ACQUIRE enters ACQUIRE on the next cycle
    p_clear_enters_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACQ && acq_req) |=> (state_q == ST_ACQ));

    // R2: capture strobes only come out while acquiring
    p_cap_in_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> (state_q == ST_ACQ));

    // R7: playback strobes only follow a cycle spent in REPLAY
    p_play_from_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        play_stb |-> ($past(state_q) == ST_REPLAY));

    // R8: the two strobes never overlap
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_stb && play_stb));

    // R6: without an acquire request IDLE is left for nothing
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !acq_req) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/replay_field_sched.sv
module replay_field_sched
    import rps_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int INSET_N = 4,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_start,
    input  logic [1:0]         acq_rate,
    input  logic               save_clear,
    input  logic [1:0]         play_rate,
    input  logic               play_go,
    input  logic [INSET_N-1:0] inset_on,
    output logic               cap_stb,
    output logic [SLOT_W-1:0]  cap_slot,
    output logic               play_stb,
    output logic [SLOT_W-1:0]  play_slot,
    output logic [1:0]         status
);

    logic             acq_req;
    logic             clear;
    logic             play_load;
    logic             cap_adv;
    logic             play_adv;
    logic             cap_fire;
    logic             play_fire;
    logic             empty;
    logic             last;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    rps_state_e       state;

    // The save/clear command only counts while every inset is off.
    assign acq_req = save_clear && (inset_on == '0);
    assign status  = state;

    rps_field_div #(.W(DIV_W)) u_cap_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .adv    (cap_adv),
        .period (acq_period(acq_rate)),
        .fire   (cap_fire)
    );

    rps_field_div #(.W(DIV_W)) u_play_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (play_load),
        .adv    (play_adv),
        .period (play_period(acq_rate, play_rate)),
        .fire   (play_fire)
    );

    rps_slot_ring #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .cap_fire  (cap_fire),
        .play_load (play_load),
        .play_fire (play_fire),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot),
        .empty     (empty),
        .last      (last)
    );

    rps_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .acq_req     (acq_req),
        .play_go     (play_go),
        .empty       (empty),
        .last        (last),
        .cap_fire    (cap_fire),
        .play_fire   (play_fire),
        .wr_slot     (wr_slot),
        .rd_slot     (rd_slot),
        .clear       (clear),
        .play_load   (play_load),
        .cap_adv     (cap_adv),
        .play_adv    (play_adv),
        .state       (state),
        .cap_stb     (cap_stb),
        .cap_slot    (cap_slot),
        .play_stb    (play_stb),
        .play_slot   (play_slot)
    );

    // R4: with any inset on, ACQUIRE cannot be entered
    p_inset_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01 && inset_on != '0) |=> (status != 2'b01));

    // R9: REPLAY is only entered from FROZEN
    p_replay_from_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11 && $past(status) != 2'b11) |-> ($past(status) == 2'b10));

endmodule

// File: tb/replay_field_sched_test.sv
module replay_field_sched_test;

    localparam int D  = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          field_start;
    logic [1:0]    acq_rate;
    logic          save_clear;
    logic [1:0]    play_rate;
    logic          play_go;
    logic [3:0]    inset_on;
    logic          cap_stb;
    logic [SW-1:0] cap_slot;
    logic          play_stb;
    logic [SW-1:0] play_slot;
    logic [1:0]    status;

    always #5 clk = ~clk;

    replay_field_sched #(.DEPTH(D), .INSET_N(4)) uut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .acq_rate(acq_rate),
        .save_clear(save_clear), .play_rate(play_rate), .play_go(play_go),
        .inset_on(inset_on), .cap_stb(cap_stb), .cap_slot(cap_slot),
        .play_stb(play_stb), .play_slot(play_slot), .status(status)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic          s_cap, s_play;
    logic [SW-1:0] s_cs, s_ps;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One field pulse; samples the registered strobes, then checks they dropped (R8).
    task automatic pulse_field();
        field_start = 1'b1;
        @(negedge clk);
        s_cap  = cap_stb;
        s_cs   = cap_slot;
        s_play = play_stb;
        s_ps   = play_slot;
        field_start = 1'b0;
        @(negedge clk);
        chk("R8 strobe one cycle", int'(cap_stb) + int'(play_stb), 0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; field_start = 0; acq_rate = 0; save_clear = 0;
        play_rate = 0; play_go = 0; inset_on = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset strobes", int'(cap_stb) + int'(play_stb), 0);

        // R6: play request in IDLE ignored
        play_go = 1; tick(2);
        chk("R6 go ignored in idle", int'(status), 0);
        play_go = 0; tick(1);

        // R5: acquire with no fields, then release -> IDLE
        save_clear = 1; tick(2);
        chk("R9 acquire code", int'(status), 1);
        save_clear = 0; tick(2);
        chk("R5 empty release to idle", int'(status), 0);

        // Near-exhaustive sweep over rate codes and capture counts
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    int c, n, p, m, oldest, last_j;
                    c = (ci == 0) ? 1 : (ci == 1) ? 3 : (ci == 2) ? 4 : 6;
                    n = 4 + 2 * a;
                    p = n << s;
                    m = (c < D) ? c : D;
                    oldest = (c >= D) ? (c % D) : 0;
                    acq_rate = 2'(a); play_rate = 2'(s);

                    save_clear = 1; tick(2);
                    chk("R3 clear enters acquire", int'(status), 1);
                    for (int i = 0; i < c * n; i++) begin
                        pulse_field();
                        chk("R2 capture decimation", int'(s_cap), (i % n == 0) ? 1 : 0);
                        if (i % n == 0)
                            chk("R2 capture slot", int'(s_cs), (i / n) % D);
                    end
                    save_clear = 0; tick(2);
                    chk("R5 freeze", int'(status), 2);
                    for (int k = 0; k < 2; k++) begin
                        pulse_field();
                        chk("R5 no capture frozen", int'(s_cap), 0);
                    end

                    play_go = 1; tick(2);
                    chk("R6 start replay", int'(status), 3);
                    last_j = (m - 1) * p;
                    for (int j = 0; j <= last_j; j++) begin
                        pulse_field();
                        chk("R7 play timing", int'(s_play), (j % p == 0) ? 1 : 0);
                        if (j % p == 0)
                            chk("R7 play slot", int'(s_ps), (oldest + j / p) % D);
                        chk("R7 replay status", int'(status), (j == last_j) ? 2 : 3);
                    end
                    for (int k = 0; k < 2; k++) begin
                        pulse_field();
                        chk("R7 no strobe after newest", int'(s_play), 0);
                    end
                    chk("R6 held go no restart", int'(status), 2);
                    play_go = 0; tick(1);
                end
            end
        end

        // R4: save_clear with an inset on is ignored
        inset_on = 4'b0100; save_clear = 1; tick(2);
        chk("R4 inset blocks clear", int'(status), 2);
        pulse_field();
        chk("R4 no capture with inset", int'(s_cap), 0);
        save_clear = 0; inset_on = 0; tick(1);
        play_go = 1; tick(2);
        chk("R4 store kept", int'(status), 3);
        pulse_field();
        chk("R4 oldest slot kept", int'(s_ps), 2);

        // R3: clear aborts a running replay and empties the store
        save_clear = 1; tick(2);
        chk("R3 abort replay", int'(status), 1);
        acq_rate = 0;
        pulse_field();
        chk("R3 capture after clear", int'(s_cap), 1);
        chk("R3 slot restarts", int'(s_cs), 0);
        play_go = 0; save_clear = 0; tick(2);
        chk("R5 one capture frozen", int'(status), 2);
        play_rate = 0;
        play_go = 1; tick(2);
        pulse_field();
        chk("R3 replay of one slot", int'(s_ps), 0);
        chk("R3 count reset ends replay", int'(status), 2);
        play_go = 0; tick(1);

        // R6: play_go raised during acquire then held does not start replay
        save_clear = 1; play_go = 1; tick(2);
        chk("R6 go ignored in acquire", int'(status), 1);
        pulse_field();
        save_clear = 0; tick(2);
        chk("R6 held go after freeze", int'(status), 2);
        play_go = 0; tick(1);

        // R1: reset again mid-operation
        rst_n = 0; tick(1); rst_n = 1; tick(1);
        chk("R1 reset returns idle", int'(status), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule